// File: doc/BRIEF.md
# Runtime Cache-Line Fault Classifier

This block sorts the lines of a write-through cache into fault classes while the cache runs at low supply voltage, with no self-test pass. Each line keeps a parity bit, which detects errors but cannot correct them. A small shared pool of SECDED check-bit entries is handed out only to lines that have shown a parity error. That entry separates a line with exactly one faulty bit, which stays in use and is corrected on every read, from a line with two or more faulty bits, which is retired for good.

The tag lookup, the data and parity arrays, replacement and voltage control all sit outside. On a read, the tag logic presents the line index, its tag-match result, the stored data and the stored parity bit. In the same cycle the block answers hit or miss, returns the (possibly corrected) data, and asks for the line to be invalidated when its contents cannot be trusted. Because the cache is write-through, dropping a line costs only a refetch. On a fill, the block returns the parity bit to store and records SECDED check bits when the line owns a pool entry. A per-line usable mask lets the replacement logic skip retired lines. Two counters report how many lines are single-fault protected and how many are retired. A synchronous clear, raised on entry to a new voltage mode, forgets all of this.

Top module: `line_fault_classifier`

## Requirements
- R1: `fill_par` equals the XOR of all bits of `fill_data` (even parity), in the same cycle as the fill.
- R2: A tag-matching read of a line with no recorded fault and correct parity (XOR of `rd_data` and `rd_par` is 0) is a hit, returns `rd_data` unchanged, and does not raise `rd_inval`.
- R3: A tag-matching read of a line with no recorded fault and a parity error is a miss with `rd_inval` raised. If a pool entry is free, the line takes it and stays usable.
- R4: When that parity error finds no free pool entry, the line is retired at once: its `line_usable` bit goes to 0 and `cnt_dead` goes up by one.
- R5: On a line that owns a pool entry, the parity bit is ignored. A read with zero or one flipped data bit (relative to the last fill) is a hit that returns the filled data.
- R6: The first single-bit correction on a line that owns a pool entry marks it single-fault protected and raises `cnt_single` by one. Later corrections on the same line do not raise it again.
- R7: A read of a line that owns a pool entry, with two data bits flipped, is a miss with `rd_inval`. The line is retired, its entry is freed for reuse, and if the line was counted as single-fault, `cnt_single` drops by one.
- R8: A retired line never hits and never raises `rd_inval`, even when its tag matches. It stays retired until `mode_clr`.
- R9: A read with `rd_tag_hit` low is a miss, raises no `rd_inval`, and changes no line state or counter.
- R10: `mode_clr` returns every line to usable with no recorded fault, frees every pool entry, and zeroes both counters on the next clock edge. The same holds after `rst_n`.
- R11: `cnt_dead` always equals the number of zero bits in `line_usable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_clr | input | 1 | Synchronous clear on voltage-mode entry |
| rd_valid | input | 1 | Read lookup present |
| rd_line | input | LW | Line index of the lookup |
| rd_tag_hit | input | 1 | Tag of the line matches |
| rd_data | input | DATA_W | Data word read from the array |
| rd_par | input | 1 | Parity bit read from the array |
| rd_hit | output | 1 | Lookup hits; `rd_data_out` is valid |
| rd_miss | output | 1 | Lookup misses; the line must be fetched from the next level |
| rd_inval | output | 1 | Line contents are untrusted; invalidate its tag |
| rd_data_out | output | DATA_W | Data after correction |
| fill_valid | input | 1 | Line fill present |
| fill_line | input | LW | Line index being filled |
| fill_data | input | DATA_W | Data being written |
| fill_par | output | 1 | Parity bit to store with the fill |
| line_usable | output | NUM_LINES | One bit per line; 0 means retired |
| cnt_single | output | CW | Number of single-fault protected lines |
| cnt_dead | output | CW | Number of retired lines |

## Verification
Clean reads with both correct and wrong parity show that the parity check applies only to lines without a pool entry, and that it is ignored on lines with one. Every single-bit flip of the word goes to one protected line, which shows that each syndrome points at the right data bit and that the single-fault count rises only once. Every pair of flipped bits goes, after a clear, to a freshly protected line, which shows that every double error is told apart from a single error and retires the line. Pool exhaustion, entry reuse after a retirement, tag misses on suspect lines and the mode clear each check one classification path at the boundary it guards.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic [1:0] {
    LS_CLEAN  = 2'b00,
    LS_TEST   = 2'b01,
    LS_SINGLE = 2'b10,
    LS_DEAD   = 2'b11
  } line_state_e;

  // Hamming check-bit count for a data width (overall parity excluded)
  function automatic int hamming_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  // Codeword position of data bit j (positions that are not powers of two)
  function automatic int data_pos(input int j);
    int cnt;
    int res;
    cnt = -1;
    res = 0;
    for (int q = 3; q < 1024; q++) begin
      if ((q & (q - 1)) != 0 && res == 0) begin
        cnt++;
        if (cnt == j) res = q;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/lfc_secded_enc.sv
module lfc_secded_enc #(
  parameter int DW = 16,
  localparam int RB = lfc_pkg::hamming_bits(DW)
) (
  input  logic [DW-1:0] data,
  output logic [RB:0]   chk
);

  function automatic logic [DW-1:0] build_mask(input int i);
    logic [DW-1:0] m;
    for (int j = 0; j < DW; j++) m[j] = ((lfc_pkg::data_pos(j) >> i) & 1) == 1;
    return m;
  endfunction

  logic [RB-1:0] ham;

  for (genvar i = 0; i < RB; i++) begin : g_chk
    localparam logic [DW-1:0] MASK = build_mask(i);
    assign ham[i] = ^(data & MASK);
  end

  assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/lfc_secded_dec.sv
module lfc_secded_dec #(
  parameter int DW = 16,
  localparam int RB = lfc_pkg::hamming_bits(DW)
) (
  input  logic [DW-1:0] data,
  input  logic [RB:0]   chk_st,
  output logic [DW-1:0] data_fix,
  output logic          err_single,
  output logic          err_double
);

  logic [RB:0]   rc;
  logic [RB-1:0] syn;
  logic          ovr_err;
  logic [DW-1:0] flip;

  lfc_secded_enc #(.DW(DW)) u_enc (.data(data), .chk(rc));

  assign syn     = rc[RB-1:0] ^ chk_st[RB-1:0];
  assign ovr_err = rc[RB] ^ (^syn) ^ chk_st[RB];

  assign err_single = ovr_err;
  assign err_double = !ovr_err && (syn != '0);

  for (genvar j = 0; j < DW; j++) begin : g_fix
    localparam int P = lfc_pkg::data_pos(j);
    assign flip[j] = err_single && (syn == P[RB-1:0]);
  end

  assign data_fix = data ^ flip;

endmodule

// File: rtl/lfc_ecc_pool.sv
module lfc_ecc_pool #(
  parameter int ENT = 2,
  parameter int CBW = 6,
  localparam int EW = (ENT > 1) ? $clog2(ENT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           alloc_req,
  output logic           alloc_ok,
  output logic [EW-1:0]  alloc_idx,
  input  logic           free_en,
  input  logic [EW-1:0]  free_idx,
  input  logic           wr_en,
  input  logic [EW-1:0]  wr_idx,
  input  logic [CBW-1:0] wr_chk,
  input  logic [EW-1:0]  rd_idx,
  output logic [CBW-1:0] rd_chk
);

  logic [ENT-1:0] used_q, used_d;
  logic [CBW-1:0] chk_q [ENT];

  always_comb begin
    alloc_ok  = 1'b0;
    alloc_idx = '0;
    for (int e = ENT - 1; e >= 0; e--) begin
      if (!used_q[e]) begin
        alloc_ok  = 1'b1;
        alloc_idx = EW'(e);
      end
    end
  end

  always_comb begin
    used_d = used_q;
    if (clr) begin
      used_d = '0;
    end else begin
      if (free_en) used_d[free_idx] = 1'b0;
      if (alloc_req && alloc_ok) used_d[alloc_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  for (genvar e = 0; e < ENT; e++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          chk_q[e] <= '0;
      else if (wr_en && wr_idx == EW'(e))  chk_q[e] <= wr_chk;
    end
  end

  assign rd_chk = chk_q[rd_idx];

endmodule

// File: rtl/line_fault_classifier.sv
module line_fault_classifier
  import lfc_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int DATA_W      = 16,
  parameter int ECC_ENTRIES = 2,
  localparam int LW  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CW  = $clog2(NUM_LINES + 1),
  localparam int EW  = (ECC_ENTRIES > 1) ? $clog2(ECC_ENTRIES) : 1,
  localparam int CBW = hamming_bits(DATA_W) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_clr,
  input  logic                 rd_valid,
  input  logic [LW-1:0]        rd_line,
  input  logic                 rd_tag_hit,
  input  logic [DATA_W-1:0]    rd_data,
  input  logic                 rd_par,
  output logic                 rd_hit,
  output logic                 rd_miss,
  output logic                 rd_inval,
  output logic [DATA_W-1:0]    rd_data_out,
  input  logic                 fill_valid,
  input  logic [LW-1:0]        fill_line,
  input  logic [DATA_W-1:0]    fill_data,
  output logic                 fill_par,
  output logic [NUM_LINES-1:0] line_usable,
  output logic [CW-1:0]        cnt_single,
  output logic [CW-1:0]        cnt_dead
);

  line_state_e   st_q  [NUM_LINES];
  line_state_e   st_d  [NUM_LINES];
  logic [EW-1:0] ent_q [NUM_LINES];
  logic [EW-1:0] ent_d [NUM_LINES];
  logic [CW-1:0] cnt_single_d, cnt_dead_d;

  line_state_e   cur_st;
  logic          access, par_bad;
  logic          alloc_req, alloc_ok, free_en, wr_en;
  logic [EW-1:0] alloc_idx;
  logic [CBW-1:0] pool_chk, fill_chk;
  logic [DATA_W-1:0] dec_data;
  logic          dec_single, dec_double;

  assign cur_st  = st_q[rd_line];
  assign access  = rd_valid && rd_tag_hit;
  assign par_bad = (^rd_data) ^ rd_par;

  lfc_secded_dec #(.DW(DATA_W)) u_dec (
    .data(rd_data), .chk_st(pool_chk),
    .data_fix(dec_data), .err_single(dec_single), .err_double(dec_double)
  );

  lfc_secded_enc #(.DW(DATA_W)) u_fill_enc (.data(fill_data), .chk(fill_chk));

  assign fill_par = ^fill_data;
  assign wr_en    = fill_valid &&
                    (st_q[fill_line] == LS_TEST || st_q[fill_line] == LS_SINGLE);

  lfc_ecc_pool #(.ENT(ECC_ENTRIES), .CBW(CBW)) u_pool (
    .clk(clk), .rst_n(rst_n), .clr(mode_clr),
    .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_idx(alloc_idx),
    .free_en(free_en), .free_idx(ent_q[rd_line]),
    .wr_en(wr_en), .wr_idx(ent_q[fill_line]), .wr_chk(fill_chk),
    .rd_idx(ent_q[rd_line]), .rd_chk(pool_chk)
  );

  // read response and classification, next state
  always_comb begin
    rd_hit       = 1'b0;
    rd_inval     = 1'b0;
    rd_data_out  = rd_data;
    alloc_req    = 1'b0;
    free_en      = 1'b0;
    st_d         = st_q;
    ent_d        = ent_q;
    cnt_single_d = cnt_single;
    cnt_dead_d   = cnt_dead;
    if (access && !mode_clr) begin
      unique case (cur_st)
        LS_CLEAN: begin
          if (!par_bad) begin
            rd_hit = 1'b1;
          end else begin
            rd_inval  = 1'b1;
            alloc_req = 1'b1;
            if (alloc_ok) begin
              st_d[rd_line]  = LS_TEST;
              ent_d[rd_line] = alloc_idx;
            end else begin
              st_d[rd_line] = LS_DEAD;
              cnt_dead_d    = cnt_dead + 1'b1;
            end
          end
        end
        LS_TEST, LS_SINGLE: begin
          if (dec_double) begin
            rd_inval      = 1'b1;
            free_en       = 1'b1;
            st_d[rd_line] = LS_DEAD;
            cnt_dead_d    = cnt_dead + 1'b1;
            if (cur_st == LS_SINGLE) cnt_single_d = cnt_single - 1'b1;
          end else begin
            rd_hit      = 1'b1;
            rd_data_out = dec_data;
            if (dec_single && cur_st == LS_TEST) begin
              st_d[rd_line] = LS_SINGLE;
              cnt_single_d  = cnt_single + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
    if (mode_clr) begin
      for (int l = 0; l < NUM_LINES; l++) st_d[l] = LS_CLEAN;
      cnt_single_d = '0;
      cnt_dead_d   = '0;
    end
  end

  assign rd_miss = rd_valid && !rd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_single <= '0;
      cnt_dead   <= '0;
    end else begin
      cnt_single <= cnt_single_d;
      cnt_dead   <= cnt_dead_d;
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[l]  <= LS_CLEAN;
        ent_q[l] <= '0;
      end else begin
        st_q[l]  <= st_d[l];
        ent_q[l] <= ent_d[l];
      end
    end
    assign line_usable[l] = (st_q[l] != LS_DEAD);
  end

endmodule

// File: rtl/lfc_checker.sv
module lfc_checker #(
  parameter int NUM_LINES = 4,
  parameter int LW = 2,
  parameter int CW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mode_clr,
  input logic                 rd_valid,
  input logic [LW-1:0]        rd_line,
  input logic                 rd_tag_hit,
  input logic                 rd_hit,
  input logic                 rd_miss,
  input logic                 rd_inval,
  input logic [NUM_LINES-1:0] line_usable,
  input logic [CW-1:0]        cnt_single,
  input logic [CW-1:0]        cnt_dead
);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_sticky
    p_dead_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_usable[l] && !mode_clr) |=> !line_usable[l]);
  end

  p_dead_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !line_usable[rd_line]) |-> (!rd_hit && !rd_inval));

  p_tag_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_tag_hit) |-> (rd_miss && !rd_inval));

  p_inval_is_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inval |-> rd_miss);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clr |=> ((&line_usable) && cnt_single == '0 && cnt_dead == '0));

  p_dead_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_dead) + $countones(line_usable)) == NUM_LINES);

  p_single_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_single) + int'(cnt_dead)) <= NUM_LINES);

endmodule

bind line_fault_classifier lfc_checker #(
  .NUM_LINES(NUM_LINES), .LW(LW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_clr(mode_clr),
  .rd_valid(rd_valid), .rd_line(rd_line), .rd_tag_hit(rd_tag_hit),
  .rd_hit(rd_hit), .rd_miss(rd_miss), .rd_inval(rd_inval),
  .line_usable(line_usable), .cnt_single(cnt_single), .cnt_dead(cnt_dead)
);

// File: tb/line_fault_classifier_test.sv
module line_fault_classifier_test;

  localparam int L  = 4;
  localparam int DW = 16;

  logic          clk, rst_n, mode_clr;
  logic          rd_valid, rd_tag_hit, rd_par;
  logic [1:0]    rd_line, fill_line;
  logic [DW-1:0] rd_data, rd_data_out, fill_data;
  logic          rd_hit, rd_miss, rd_inval, fill_valid, fill_par;
  logic [L-1:0]  line_usable;
  logic [2:0]    cnt_single, cnt_dead;

  int n_cmp, n_bad;
  bit done;

  // values sampled during the last read
  logic          s_hit, s_miss, s_inval;
  logic [DW-1:0] s_data;

  line_fault_classifier #(.NUM_LINES(L), .DATA_W(DW), .ECC_ENTRIES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode_clr(mode_clr),
    .rd_valid(rd_valid), .rd_line(rd_line), .rd_tag_hit(rd_tag_hit),
    .rd_data(rd_data), .rd_par(rd_par),
    .rd_hit(rd_hit), .rd_miss(rd_miss), .rd_inval(rd_inval), .rd_data_out(rd_data_out),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
    .fill_par(fill_par), .line_usable(line_usable),
    .cnt_single(cnt_single), .cnt_dead(cnt_dead)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] ln, input logic [DW-1:0] d,
                         input logic p, input logic th);
    @(negedge clk);
    rd_valid = 1'b1; rd_line = ln; rd_data = d; rd_par = p; rd_tag_hit = th;
    #1;
    s_hit = rd_hit; s_miss = rd_miss; s_inval = rd_inval; s_data = rd_data_out;
    @(posedge clk); #1;
    rd_valid = 1'b0; rd_tag_hit = 1'b0;
  endtask

  task automatic do_fill(input logic [1:0] ln, input logic [DW-1:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_line = ln; fill_data = d;
    #1;
    check("R1 fill parity", 32'(fill_par), 32'(^d));
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); mode_clr = 1'b1;
    @(posedge clk); #1; mode_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d0, d1, dx;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; mode_clr = 1'b0; rd_valid = 1'b0; rd_tag_hit = 1'b0;
    rd_line = '0; rd_data = '0; rd_par = 1'b0;
    fill_valid = 1'b0; fill_line = '0; fill_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset usable", 32'(line_usable), 32'hF);
    check("R10 reset single count", 32'(cnt_single), 0);
    check("R10 reset dead count", 32'(cnt_dead), 0);

    d0 = 16'h3C5A;
    d1 = 16'h9E17;
    // R2: clean line, good parity
    do_read(2'd0, d0, ^d0, 1'b1);
    check("R2 hit", 32'(s_hit), 1);
    check("R2 data", 32'(s_data), 32'(d0));
    check("R2 no inval", 32'(s_inval), 0);

    // R9: tag miss with bad parity changes nothing
    do_read(2'd1, d1, ~^d1, 1'b0);
    check("R9 miss", 32'(s_miss), 1);
    check("R9 no inval", 32'(s_inval), 0);

    // R3: parity error on line 0 takes entry
    do_read(2'd0, d0, ~^d0, 1'b1);
    check("R3 miss", 32'(s_miss), 1);
    check("R3 inval", 32'(s_inval), 1);
    check("R3 still usable", 32'(line_usable), 32'hF);
    do_fill(2'd0, d0);

    // R5: clean read with wrong parity on protected line
    do_read(2'd0, d0, ~^d0, 1'b1);
    check("R5 parity ignored hit", 32'(s_hit), 1);
    check("R5 clean data", 32'(s_data), 32'(d0));
    check("R6 no count on clean", 32'(cnt_single), 0);

    // R5/R6: every single-bit flip
    for (int b = 0; b < DW; b++) begin
      do_read(2'd0, d0 ^ (16'd1 << b), ^d0, 1'b1);
      check("R5 single hit", 32'(s_hit), 1);
      check("R5 corrected", 32'(s_data), 32'(d0));
      check("R6 single count", 32'(cnt_single), 1);
    end

    // R3 second entry, R4 pool exhausted
    do_read(2'd1, d1, ~^d1, 1'b1);
    check("R3 line1 inval", 32'(s_inval), 1);
    check("R3 line1 usable", 32'(line_usable), 32'hF);
    do_read(2'd2, d1, ~^d1, 1'b1);
    check("R4 inval", 32'(s_inval), 1);
    check("R4 retired", 32'(line_usable), 32'hB);
    check("R4 dead count", 32'(cnt_dead), 1);

    // R8: retired line never hits
    do_read(2'd2, d1, ^d1, 1'b1);
    check("R8 miss", 32'(s_miss), 1);
    check("R8 no inval", 32'(s_inval), 0);

    // R7: double error on line 1 frees its entry
    do_fill(2'd1, d1);
    do_read(2'd1, d1 ^ 16'h0081, ^d1, 1'b1);
    check("R7 miss", 32'(s_miss), 1);
    check("R7 inval", 32'(s_inval), 1);
    check("R7 retired", 32'(line_usable), 32'h9);
    check("R7 dead count", 32'(cnt_dead), 2);
    // freed entry reused by line 3
    do_read(2'd3, d1, ~^d1, 1'b1);
    check("R7 reuse usable", 32'(line_usable), 32'h9);
    do_fill(2'd3, d1);
    do_read(2'd3, d1 ^ 16'h0400, ~^d1, 1'b1);
    check("R7 reuse corrected", 32'(s_data), 32'(d1));
    check("R6 second single", 32'(cnt_single), 2);
    // double on single-fault line 0 drops the count
    do_read(2'd0, d0 ^ 16'h1100, ^d0, 1'b1);
    check("R7 single to dead", 32'(cnt_single), 1);
    check("R11 dead count", 32'(cnt_dead), 3);
    check("R8 sticky", 32'(line_usable), 32'h8);

    // R10: mode clear
    do_clear();
    check("R10 clear usable", 32'(line_usable), 32'hF);
    check("R10 clear single", 32'(cnt_single), 0);
    check("R10 clear dead", 32'(cnt_dead), 0);
    do_read(2'd2, d0, ^d0, 1'b1);
    check("R10 cleared line hits", 32'(s_hit), 1);

    // R7: every double-bit pair
    for (int i = 0; i < DW; i++) begin
      for (int j = i + 1; j < DW; j++) begin
        dx = 16'hA5C3 ^ 16'(i * 37 + j * 11);
        do_clear();
        do_read(2'd1, dx, ~^dx, 1'b1);
        do_fill(2'd1, dx);
        do_read(2'd1, dx ^ (16'd1 << i) ^ (16'd1 << j), ^dx, 1'b1);
        check("R7 pair miss", 32'(s_miss), 1);
        check("R7 pair inval", 32'(s_inval), 1);
        check("R7 pair retired", 32'(line_usable), 32'hD);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule